// File: doc/BRIEF.md
# Token-Gated Row Hit Buffer

One of these buffers sits at the end of each pixel row. A token travels along the row and stops at every pixel that has a hit. At each stop, that pixel drives its column address and its 3-bit conversion value onto a shared row bus, with a valid strobe. On every token-clock edge that carries a valid word, the buffer loads the word into stage 0 and moves each stored entry one stage deeper. A hit counter tracks how many entries are meaningful.

When the token comes back out of the row, the buffer stops taking words. It keeps its contents, count and overflow flag unchanged until the readout side pulses a release, which empties the buffer for the next row scan. The stages are exposed in parallel. Stage 0 holds the newest hit and stage count-1 holds the oldest. When more hits arrive than there are stages, the first DEPTH hits are kept, later hits are dropped, and a sticky overflow flag is set.

Top module: `row_hit_buffer`

## Requirements
- R1: While rst_ni is low, and after it is released, hit_cnt_o is 0, ovf_o is 0 and every bit of ent_vld_o is 0.
- R2: In the capturing state, a cycle with hit_vld_i=1, tok_ret_i=0, release_i=0 and hit_cnt_o<DEPTH loads the bus word into stage 0 and moves stage k to stage k+1. After that edge, hit_cnt_o has grown by exactly one.
- R3: A cycle with hit_vld_i=0 changes neither the stage contents nor hit_cnt_o.
- R4: A cycle with tok_ret_i=1 and release_i=0 captures nothing, not even the word on the bus in that cycle. From then on, every bus word is ignored and the contents, count and overflow flag hold until release_i is pulsed.
- R5: hit_cnt_o never exceeds DEPTH. A valid word that arrives while capturing with hit_cnt_o==DEPTH is dropped and sets ovf_o. ovf_o then stays high until release_i.
- R6: release_i=1 overrides every other input. After that edge, hit_cnt_o=0, ovf_o=0 and ent_vld_o=0, and capture resumes on the next cycle.
- R7: ent_vld_o[k] is 1 exactly when k < hit_cnt_o. Stage hit_cnt_o-1 holds the oldest retained hit.
- R8: For each stage k, the address field is ent_addr_o[k*ADDR_W +: ADDR_W] and the value field is ent_data_o[k*DATA_W +: DATA_W]. Both fields match the bus word that was captured into that stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Token clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_vld_i | input | 1 | Row bus word is a hit |
| hit_addr_i | input | ADDR_W | Column address on the row bus |
| hit_data_i | input | DATA_W | Pixel conversion value on the row bus |
| tok_ret_i | input | 1 | Token has left the row |
| release_i | input | 1 | Readout frees the buffer |
| ent_vld_o | output | DEPTH | Per-stage valid bits |
| ent_addr_o | output | DEPTH*ADDR_W | Stage addresses, stage 0 in the low bits |
| ent_data_o | output | DEPTH*DATA_W | Stage values, stage 0 in the low bits |
| hit_cnt_o | output | $clog2(DEPTH+1) | Number of captured hits |
| ovf_o | output | 1 | Sticky overflow |

## Verification
The assertions rely on release_i being a clean single-clock pulse. They also rely on the bus inputs settling before each token-clock edge, because the valid-stability property reads hit_vld_i as sampled at that edge.

The bench changes every input only on the falling clock edge, so each value is stable when the rising edge samples it. It pulses release_i for one cycle between scans and holds tok_ret_i for a single cycle. The bench also sends deliberately invalid bus words, words after the token has returned, and a release together with a valid hit. These are legal stimuli and the properties must hold for all of them.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  typedef enum logic {
    ST_CAPTURE = 1'b0,
    ST_HOLD    = 1'b1
  } rhb_state_e;
endpackage

// File: rtl/rhb_ctrl.sv
module rhb_ctrl
  import rhb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic release_i,
  input  logic tok_ret_i,
  input  logic hit_vld_i,
  input  logic full_i,
  output logic clear_o,
  output logic accept_o,
  output logic drop_o
);
  rhb_state_e state_q, state_d;
  logic capture;

  always_comb begin
    state_d = state_q;
    if (release_i)                                  state_d = ST_CAPTURE;
    else if (state_q == ST_CAPTURE && tok_ret_i)    state_d = ST_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_CAPTURE;
    else         state_q <= state_d;
  end

  // the word present while the token returns is not captured
  assign capture  = (state_q == ST_CAPTURE) && !release_i && !tok_ret_i && hit_vld_i;
  assign clear_o  = release_i;
  assign accept_o = capture && !full_i;
  assign drop_o   = capture && full_i;
endmodule

// File: rtl/rhb_counter.sv
module rhb_counter #(
  parameter int unsigned DEPTH = 18,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic             drop_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CntMax = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (inc_i)  cnt_q <= cnt_q + 1'b1;
      if (drop_i) ovf_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CntMax);
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/rhb_shift_chain.sv
module rhb_shift_chain #(
  parameter int unsigned DEPTH  = 18,
  parameter int unsigned WORD_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    shift_i,
  input  logic [WORD_W-1:0]       word_i,
  output logic [DEPTH-1:0]        vld_o,
  output logic [DEPTH*WORD_W-1:0] words_o
);
  logic [WORD_W-1:0] stage_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    logic [WORD_W-1:0] nxt_word;
    logic              nxt_vld;
    if (k == 0) begin : g_head
      assign nxt_word = word_i;
      assign nxt_vld  = 1'b1;
    end else begin : g_body
      assign nxt_word = stage_q[k-1];
      assign nxt_vld  = vld_q[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[k] <= '0;
        vld_q[k]   <= 1'b0;
      end else if (clear_i) begin
        vld_q[k]   <= 1'b0;
      end else if (shift_i) begin
        stage_q[k] <= nxt_word;
        vld_q[k]   <= nxt_vld;
      end
    end

    assign words_o[k*WORD_W +: WORD_W] = stage_q[k];
  end

  assign vld_o = vld_q;
endmodule

// File: rtl/row_hit_buffer.sv
module row_hit_buffer #(
  parameter int unsigned DEPTH  = 18,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 3,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hit_vld_i,
  input  logic [ADDR_W-1:0]       hit_addr_i,
  input  logic [DATA_W-1:0]       hit_data_i,
  input  logic                    tok_ret_i,
  input  logic                    release_i,
  output logic [DEPTH-1:0]        ent_vld_o,
  output logic [DEPTH*ADDR_W-1:0] ent_addr_o,
  output logic [DEPTH*DATA_W-1:0] ent_data_o,
  output logic [CNT_W-1:0]        hit_cnt_o,
  output logic                    ovf_o
);
  localparam int unsigned WordW = ADDR_W + DATA_W;

  logic clear, accept, drop, full;
  logic [DEPTH*WordW-1:0] words;

  rhb_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .release_i (release_i),
    .tok_ret_i (tok_ret_i),
    .hit_vld_i (hit_vld_i),
    .full_i    (full),
    .clear_o   (clear),
    .accept_o  (accept),
    .drop_o    (drop)
  );

  rhb_counter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .inc_i   (accept),
    .drop_i  (drop),
    .cnt_o   (hit_cnt_o),
    .full_o  (full),
    .ovf_o   (ovf_o)
  );

  rhb_shift_chain #(.DEPTH(DEPTH), .WORD_W(WordW)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .shift_i (accept),
    .word_i  ({hit_addr_i, hit_data_i}),
    .vld_o   (ent_vld_o),
    .words_o (words)
  );

  // split packed stage words into address and value fields
  for (genvar k = 0; k < DEPTH; k++) begin : g_split
    assign ent_addr_o[k*ADDR_W +: ADDR_W] = words[k*WordW + DATA_W +: ADDR_W];
    assign ent_data_o[k*DATA_W +: DATA_W] = words[k*WordW +: DATA_W];
  end
endmodule

// File: rtl/row_hit_buffer_chk.sv
module row_hit_buffer_chk #(
  parameter int unsigned DEPTH  = 18,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hit_vld_i,
  input logic             tok_ret_i,
  input logic             release_i,
  input logic [DEPTH-1:0] ent_vld_o,
  input logic [CNT_W-1:0] hit_cnt_o,
  input logic             ovf_o
);
  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (hit_cnt_o == '0 && !ovf_o && ent_vld_o == '0); // R1
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_cnt_o <= CNT_W'(DEPTH)); // R5

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !release_i |=> (hit_cnt_o == $past(hit_cnt_o) || hit_cnt_o == $past(hit_cnt_o) + 1'b1)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_vld_i && !release_i) |=> ($stable(hit_cnt_o) && $stable(ent_vld_o))); // R3

  AST_TOKEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_ret_i && !release_i) |=> ($stable(hit_cnt_o) && $stable(ent_vld_o))); // R4

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !release_i) |=> ovf_o); // R5

  AST_RELEASE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> (hit_cnt_o == '0 && !ovf_o && ent_vld_o == '0)); // R6

  AST_VLD_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ent_vld_o) == int'(hit_cnt_o)); // R7

  AST_VLD_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_vld_o & DEPTH'(ent_vld_o + 1'b1)) == '0); // R7
endmodule

bind row_hit_buffer row_hit_buffer_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hit_vld_i (hit_vld_i),
  .tok_ret_i (tok_ret_i),
  .release_i (release_i),
  .ent_vld_o (ent_vld_o),
  .hit_cnt_o (hit_cnt_o),
  .ovf_o     (ovf_o)
);

// File: tb/tb_row_hit_buffer.sv
module tb_row_hit_buffer;
  localparam int D  = 5;
  localparam int AW = 4;
  localparam int DW = 3;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic hit_vld = 1'b0, tok_ret = 1'b0, rel = 1'b0;
  logic [AW-1:0] hit_addr = '0;
  logic [DW-1:0] hit_data = '0;
  logic [D-1:0]    ent_vld;
  logic [D*AW-1:0] ent_addr;
  logic [D*DW-1:0] ent_data;
  logic [CW-1:0]   hit_cnt;
  logic            ovf;

  int total = 0, bad = 0;
  int m_cnt = 0;
  bit m_ovf = 0, m_held = 0;
  int m_addr [D];
  int m_data [D];
  int seq = 0;

  always #5 clk = ~clk;

  row_hit_buffer #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .hit_vld_i(hit_vld), .hit_addr_i(hit_addr),
    .hit_data_i(hit_data), .tok_ret_i(tok_ret), .release_i(rel),
    .ent_vld_o(ent_vld), .ent_addr_o(ent_addr), .ent_data_o(ent_data),
    .hit_cnt_o(hit_cnt), .ovf_o(ovf)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all(string ctx);
    logic [D-1:0] ev;
    ev = D'((1 << m_cnt) - 1);
    check(int'(hit_cnt) == m_cnt, {ctx, " R2 count"}, hit_cnt, m_cnt);
    check(ovf == m_ovf, {ctx, " R5 ovf"}, ovf, m_ovf);
    check(ent_vld == ev, {ctx, " R7 valid"}, ent_vld, ev);
    for (int k = 0; k < m_cnt; k++) begin
      check(int'(ent_addr[k*AW +: AW]) == m_addr[k], {ctx, " R8 addr"}, ent_addr[k*AW +: AW], m_addr[k]);
      check(int'(ent_data[k*DW +: DW]) == m_data[k], {ctx, " R8 data"}, ent_data[k*DW +: DW], m_data[k]);
    end
  endtask

  // one token-clock cycle; called at a falling edge
  task automatic cyc(bit v, bit t, bit r, string ctx);
    int a, d;
    a = (seq * 7 + 3) % (1 << AW);
    d = seq % (1 << DW);
    seq++;
    hit_vld = v; tok_ret = t; rel = r;
    hit_addr = AW'(a); hit_data = DW'(d);
    if (r) begin
      m_cnt = 0; m_ovf = 0; m_held = 0;
    end else if (!m_held) begin
      if (t) m_held = 1;
      else if (v) begin
        if (m_cnt < D) begin
          for (int k = D - 1; k > 0; k--) begin
            m_addr[k] = m_addr[k-1];
            m_data[k] = m_data[k-1];
          end
          m_addr[0] = a; m_data[0] = d; m_cnt++;
        end else m_ovf = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    hit_vld = 0; tok_ret = 0; rel = 0;
    compare_all(ctx);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] c_snap;
    logic [D-1:0]  v_snap;
    logic [D*AW-1:0] a_snap;
    @(negedge clk);
    check(hit_cnt == 0 && ovf == 0 && ent_vld == 0, "R1 in reset", hit_cnt, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(hit_cnt == 0 && ovf == 0 && ent_vld == 0, "R1 after reset", {ovf, ent_vld}, 0);

    // sweep hit counts across and beyond depth, with idle gaps
    for (int n = 0; n <= D + 2; n++) begin
      for (int g = 0; g < 3; g++) begin
        cyc(0, 0, 1, "R6 release");
        for (int h = 0; h < n; h++) begin
          cyc(1, 0, 0, "R2 capture");
          for (int i = 0; i < (h % (g + 1)); i++) cyc(0, 0, 0, "R3 idle");
        end
        cyc(1, 1, 0, "R4 return word");
        c_snap = hit_cnt; v_snap = ent_vld; a_snap = ent_addr;
        for (int i = 0; i < 3; i++) cyc(1, i == 1, 0, "R4 frozen");
        check(hit_cnt == c_snap && ent_vld == v_snap && ent_addr == a_snap,
              "R4 snapshot", hit_cnt, c_snap);
        check(ovf == (n > D), "R5 ovf after scan", ovf, n > D);
      end
    end

    // release wins over a simultaneous hit
    cyc(1, 0, 1, "R6 release with hit");
    check(hit_cnt == 0, "R6 hit ignored", hit_cnt, 0);
    cyc(1, 0, 0, "R6 resume");
    check(hit_cnt == 1, "R6 resume capture", hit_cnt, 1);
    // idle cycles while capturing change nothing
    c_snap = hit_cnt; a_snap = ent_addr;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, "R3 idle");
    check(hit_cnt == c_snap && ent_addr == a_snap, "R3 idle stable", hit_cnt, c_snap);
    // overflow stays until release, even past token return
    for (int i = 0; i < D + 1; i++) cyc(1, 0, 0, "R5 fill");
    check(ovf == 1, "R5 ovf set", ovf, 1);
    cyc(0, 1, 0, "R5 return");
    cyc(0, 0, 0, "R5 hold");
    check(ovf == 1 && hit_cnt == D, "R5 sticky", hit_cnt, D);
    check(int'(ent_addr[(D-1)*AW +: AW]) == m_addr[D-1], "R7 oldest at top", ent_addr[(D-1)*AW +: AW], m_addr[D-1]);
    cyc(0, 0, 1, "R6 final release");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule